// File: doc/BRIEF.md
# Sequential Factorial Engine

The engine computes the factorial of an unsigned input, keeping the low `W` bits of the product. It works one multiplication per clock. An accumulator starts at one. A down-counter starts at the input value. On every step the accumulator takes the product of the two registers, and the counter drops by one. The loop ends when the value about to be written into the counter is zero. The controller is a three-state machine. Its selects and its next state come from an eight-word lookup table, addressed by the current state and that zero flag.

Reset places the engine in its load state, so a run starts on its own with whatever value sits on `n_in`. After that, a `start` pulse while the engine is finished begins a new run. The result is valid and steady while `done` is high. No flag marks a product that has wrapped past `W` bits.

Top module: `fact_engine`

## Requirements
- R1: While `rst` is high, `done` is 0 and `result` is 0.
- R2: An input of 0 gives a result of 1. The engine goes from the load cycle straight to finished, and the counter never steps below zero.
- R3: For inputs 1 to 12, `result` equals the exact factorial once `done` is high.
- R4: For inputs above 12, `result` equals the factorial reduced modulo 2^W, and nothing flags the wrap.
- R5: `start` is sampled at a rising edge while `done` is high. `done` then falls after the next edge and rises again after exactly N+1 rising edges counted from the sampling edge.
- R6: While `done` is high and `start` is low, `done` stays high and `result` does not change, even when `n_in` changes.
- R7: A `start` pulse while the engine is still working has no effect on the result or on the latency of that run.
- R8: `n_in` is read only in the load cycle. Changing it during the loop leaves the result unchanged.
- R9: After `rst` falls, a run on the value of `n_in` starts without any `start` pulse. `done` rises after N+1 rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a new run when sampled while done is high |
| n_in | input | W | Operand, read during the load cycle |
| result | output | W | Accumulator value; final factorial while done is high |
| done | output | 1 | High while the engine is finished |

## Verification
The bench builds the engine with its default width of 32 bits. At that width, every input above 12 wraps, and every input of 34 or more drives the product to exactly zero. Random inputs up to 60, plus a directed run at a few hundred, therefore exercise exact results, wrapped results and the all-zero result. The same width keeps each run short enough to count its latency edge by edge.

// File: rtl/fact_engine.sv
module fact_engine #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] n_in,
  output logic [W-1:0] result,
  output logic         done
);

  localparam logic [1:0] ST_LOAD = 2'b00;
  localparam logic [1:0] ST_RUN  = 2'b01;
  localparam logic [1:0] ST_FIN  = 2'b10;
  localparam logic [1:0] ST_BAD  = 2'b11;

  localparam logic [1:0] SEL_KEEP = 2'b00;
  localparam logic [1:0] SEL_INIT = 2'b01;
  localparam logic [1:0] SEL_STEP = 2'b10;

  // word layout: [5:4] accumulator select, [3:2] counter select, [1:0] next state
  function automatic logic [5:0] ctl_rom(input logic [2:0] addr);
    case (addr)
      {ST_LOAD, 1'b0}: ctl_rom = {SEL_INIT, SEL_INIT, ST_RUN};
      {ST_LOAD, 1'b1}: ctl_rom = {SEL_INIT, SEL_INIT, ST_FIN};
      {ST_RUN,  1'b0}: ctl_rom = {SEL_STEP, SEL_STEP, ST_RUN};
      {ST_RUN,  1'b1}: ctl_rom = {SEL_STEP, SEL_STEP, ST_FIN};
      {ST_FIN,  1'b0}: ctl_rom = {SEL_KEEP, SEL_KEEP, ST_FIN};
      {ST_FIN,  1'b1}: ctl_rom = {SEL_KEEP, SEL_KEEP, ST_FIN};
      {ST_BAD,  1'b0}: ctl_rom = {SEL_KEEP, SEL_KEEP, ST_LOAD};
      default:         ctl_rom = {SEL_KEEP, SEL_KEEP, ST_LOAD};
    endcase
  endfunction

  logic [1:0]   state_q, state_d;
  logic [W-1:0] acc_q, acc_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] prod, cnt_dec;
  logic [5:0]   sel_word, ctl_word;
  logic         zero;

  assign prod    = acc_q * cnt_q;
  assign cnt_dec = cnt_q - W'(1);

  // selects never depend on the zero flag, so the flag is formed from the Z=0 word
  assign sel_word = ctl_rom({state_q, 1'b0});

  always_comb begin
    case (sel_word[3:2])
      SEL_INIT: cnt_d = n_in;
      SEL_STEP: cnt_d = cnt_dec;
      default:  cnt_d = cnt_q;
    endcase
  end

  assign zero     = (cnt_d == '0);
  assign ctl_word = ctl_rom({state_q, zero});

  always_comb begin
    case (ctl_word[5:4])
      SEL_INIT: acc_d = W'(1);
      SEL_STEP: acc_d = prod;
      default:  acc_d = acc_q;
    endcase
  end

  assign state_d = (state_q == ST_FIN && start) ? ST_LOAD : ctl_word[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_LOAD;
      acc_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      acc_q   <= acc_d;
      cnt_q   <= cnt_d;
    end
  end

  assign result = acc_q;
  assign done   = (state_q == ST_FIN);

endmodule

module fact_engine_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] n_in,
  input logic [W-1:0] result,
  input logic         done,
  input logic [1:0]   state_q,
  input logic [W-1:0] cnt_q
);

  p_rst_quiet_r1: assert property (@(posedge clk) rst |=> !done && result == '0);

  p_zero_input_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == 2'b00 && n_in == '0) |=> done && result == W'(1));

  p_no_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == 2'b01) |-> cnt_q != '0);

  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == 2'b01) |=> cnt_q == $past(cnt_q) - W'(1));

  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> !done);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done && result == $past(result));

  p_busy_ignores_start_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == 2'b01 && start) |=> state_q != 2'b00);

  p_legal_state_r9: assert property (@(posedge clk) disable iff (rst)
    state_q != 2'b11);

endmodule

bind fact_engine fact_engine_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .n_in(n_in), .result(result),
  .done(done), .state_q(state_q), .cnt_q(cnt_q)
);

// File: tb/fact_engine_test.sv
module fact_engine_test;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] n_in = '0;
  logic [W-1:0] result;
  logic         done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fact_engine #(.W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .n_in(n_in),
    .result(result), .done(done)
  );

  function automatic logic [W-1:0] ref_fact(input int n);
    logic [W-1:0] p = W'(1);
    for (int i = 2; i <= n; i++) p = p * W'(i);
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // waits at negedges until done; returns edges seen since the sampling edge
  task automatic wait_done(output int edges);
    edges = 0;
    while (!done && edges < 5000) begin
      @(negedge clk);
      edges++;
    end
  endtask

  task automatic run(input int n, input string req, input bit poke_start, input bit poke_n);
    int edges;
    @(negedge clk);
    n_in  = W'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R5 done low after start", done, 0);
    edges = 0;
    while (!done && edges < 5000) begin
      @(negedge clk);
      edges++;
      if (edges == 2 && poke_start) start = 1'b1;
      if (edges == 3) start = 1'b0;
      if (edges == 2 && poke_n) n_in = W'(n + 3);
    end
    chk(edges == n + 1, "R5 latency", edges, n + 1);
    chk(result == ref_fact(n), req, result, ref_fact(n));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int edges;
    void'($urandom(32'd2024));
    n_in = W'(5);
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    chk(result == '0, "R1 result in reset", result, 0);
    rst = 1'b0;
    wait_done(edges);
    chk(edges == 6, "R9 latency after reset", edges, 6);
    chk(result == W'(120), "R9 result after reset", result, 120);

    run(0, "R2 zero input", 1'b0, 1'b0);
    for (int n = 1; n <= 12; n++) run(n, "R3 exact factorial", 1'b0, 1'b0);
    run(13, "R4 wrap 13", 1'b0, 1'b0);
    run(34, "R4 zero product", 1'b0, 1'b0);
    run(300, "R4 long run", 1'b0, 1'b0);

    for (int k = 0; k < 20; k++) run(int'($urandom_range(0, 60)), "R4 random input", 1'b0, 1'b0);

    run(10, "R7 start while busy", 1'b1, 1'b0);
    run(9, "R8 n_in changed during loop", 1'b0, 1'b1);

    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      n_in = $urandom();
      chk(done == 1'b1, "R6 done held", done, 1);
      chk(result == ref_fact(9), "R6 result held", result, ref_fact(9));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule